// File: doc/BRIEF.md
# Device Directory Pointer Register

This block is a 64-bit memory-mapped control register. It selects how device contexts are looked up: no translation at all, pass-through, or a directory table of one, two or three levels. It also holds the page number of the directory root. Software writes the register through a simple register-bus port and reads it back at any time. The mode and root it holds go straight to the directory walker.

The mode field legalises what is written. A request for a table depth that this build lacks reads back as a depth that it does have. A request to move directly from one table depth to another is refused. Each accepted mode change raises a busy flag for a fixed number of cycles. While that flag is set, any write is dropped. Software is expected to poll until the flag clears before it trusts the value it reads back.

A build may hold a fixed root page number. When it does, that number appears in the root field whenever the register is set to one of the two non-table modes.

Top module: `dirptr_ctrl`

## Requirements
- R1: After reset, the mode reads OFF, the root page number is zero, busy is clear, and the whole read word is zero.
- R2: Read layout is mode code in bits [3:0], busy in bit 4 and root page number in bits [53:10]. All other bits read as zero. Writes to bit 4 and to the other unused bits have no effect.
- R3: Mode codes are OFF=0, BARE=1, L1=2, L2=3, L3=4. When busy is clear, a write of OFF or BARE is accepted from any current mode.
- R4: When busy is clear, a write of a table mode L1..L(MAX_LEVELS) is stored as written, provided it is not refused under R6.
- R5: A write of a table mode deeper than MAX_LEVELS is stored as the deepest supported table mode. A write of any code from 5 to 15 is stored as OFF.
- R6: If the current mode is a table mode and the legalised written mode is a different table mode, the write is ignored. Both mode and root keep their old values.
- R7: An accepted write that changes the mode sets busy. Busy stays set for BUSY_CYCLES rising edges and clears on the last of them.
- R8: A write presented while busy reads as set is dropped. Mode, root and the busy countdown are all unchanged.
- R9: When FIXED_ROOT_EN is 1, an accepted write whose stored mode is OFF or BARE stores FIXED_ROOT as the root. Every other accepted write stores the written bits [53:10].
- R10: mode_o always equals the stored mode. root_o equals the stored root when the mode is a table mode, and zero otherwise. busy_o equals the busy bit.
- R11: An accepted write that leaves the mode unchanged updates the root and does not set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Current register contents |
| mode_o | output | 4 | Stored mode to the walker |
| root_o | output | 44 | Root page number to the walker, zero unless in a table mode |
| busy_o | output | 1 | Mode change still being applied |

## Verification
A write sampled at a rising edge shows up in rd_data, mode_o and root_o just after that same edge, because the register has a single stage. Busy rises at that edge and falls BUSY_CYCLES edges later. The bench drives inputs at the falling edge and updates its reference model at the rising edge. It then compares every output 1 ns after each rising edge, so every check sees the result of exactly one edge. Directed sequences place writes on the first and last busy cycle. Random traffic adds further writes at arbitrary spacing.

// File: rtl/dirptr_pkg.sv
package dirptr_pkg;
   localparam int unsigned DP_DATA_W   = 64;
   localparam int unsigned DP_MODE_W   = 4;
   localparam int unsigned DP_ROOT_W   = 44;
   localparam int unsigned DP_ROOT_LSB = 10;
   localparam int unsigned DP_BUSY_BIT = 4;
   localparam int unsigned DP_ROOT_MSB = DP_ROOT_LSB + DP_ROOT_W - 1;

   typedef logic [DP_MODE_W-1:0] dmode_t;
   typedef logic [DP_ROOT_W-1:0] droot_t;

   localparam dmode_t DM_OFF  = 4'd0;
   localparam dmode_t DM_BARE = 4'd1;
   localparam dmode_t DM_L1   = 4'd2;
   localparam dmode_t DM_L3   = 4'd4;

   function automatic logic is_table(input dmode_t m);
      return (m >= DM_L1) && (m <= DM_L3);
   endfunction
endpackage

// File: rtl/dirptr_legalize.sv
module dirptr_legalize
   import dirptr_pkg::*;
#(
   parameter int unsigned MAX_LEVELS = 2
) (
   input  dmode_t req_mode,
   output dmode_t legal_mode
);
   localparam dmode_t TOP_MODE = dmode_t'(MAX_LEVELS + 1);

   logic [7:0] code_ok;

   assign code_ok[0] = 1'b1;
   assign code_ok[1] = 1'b1;
   for (genvar g = 2; g < 8; g++) begin : g_ok
      if (g <= MAX_LEVELS + 1) begin : g_sup
         assign code_ok[g] = 1'b1;
      end else begin : g_uns
         assign code_ok[g] = 1'b0;
      end
   end

   always_comb begin
      if (req_mode > DM_L3)
         legal_mode = DM_OFF;
      else if (code_ok[req_mode[2:0]])
         legal_mode = req_mode;
      else
         legal_mode = TOP_MODE;
   end
endmodule

// File: rtl/dirptr_busy_timer.sv
module dirptr_busy_timer #(
   parameter int unsigned BUSY_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n)
         remain <= '0;
      else if (start)
         remain <= CNT_LOAD;
      else if (remain != '0)
         remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);
endmodule

// File: rtl/dirptr_root_sel.sv
module dirptr_root_sel
   import dirptr_pkg::*;
#(
   parameter bit     FIXED_ROOT_EN = 1'b1,
   parameter droot_t FIXED_ROOT    = '0
) (
   input  dmode_t new_mode,
   input  droot_t wr_root,
   output droot_t next_root
);
   if (FIXED_ROOT_EN) begin : g_fixed
      assign next_root = is_table(new_mode) ? wr_root : FIXED_ROOT;
   end else begin : g_free
      assign next_root = wr_root;
   end
endmodule

// File: rtl/dirptr_ctrl.sv
module dirptr_ctrl
   import dirptr_pkg::*;
#(
   parameter int unsigned MAX_LEVELS    = 2,
   parameter int unsigned BUSY_CYCLES   = 4,
   parameter bit          FIXED_ROOT_EN = 1'b1,
   parameter logic [43:0] FIXED_ROOT    = 44'h000_00AB_CDE1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [63:0] wr_data,
   output logic [63:0] rd_data,
   output logic [3:0]  mode_o,
   output logic [43:0] root_o,
   output logic        busy_o
);
   if (MAX_LEVELS < 1 || MAX_LEVELS > 3) begin : g_bad_levels
      $error("dirptr_ctrl: MAX_LEVELS must be 1, 2 or 3");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("dirptr_ctrl: BUSY_CYCLES must be at least 1");
   end

   dmode_t cur_mode, legal_mode;
   droot_t cur_root, next_root;
   logic   busy, blocked, accept, start;

   dirptr_legalize #(.MAX_LEVELS(MAX_LEVELS)) u_legal (
      .req_mode   (wr_data[DP_MODE_W-1:0]),
      .legal_mode (legal_mode)
   );

   dirptr_root_sel #(.FIXED_ROOT_EN(FIXED_ROOT_EN), .FIXED_ROOT(FIXED_ROOT)) u_root (
      .new_mode  (legal_mode),
      .wr_root   (wr_data[DP_ROOT_MSB:DP_ROOT_LSB]),
      .next_root (next_root)
   );

   assign blocked = is_table(cur_mode) && is_table(legal_mode) && (legal_mode != cur_mode);
   assign accept  = wr_en && !busy && !blocked;
   assign start   = accept && (legal_mode != cur_mode);

   dirptr_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_mode <= DM_OFF;
         cur_root <= '0;
      end else if (accept) begin
         cur_mode <= legal_mode;
         cur_root <= next_root;
      end
   end

   always_comb begin
      rd_data = '0;
      rd_data[DP_MODE_W-1:0]          = cur_mode;
      rd_data[DP_BUSY_BIT]            = busy;
      rd_data[DP_ROOT_MSB:DP_ROOT_LSB] = cur_root;
   end

   assign mode_o = cur_mode;
   assign root_o = is_table(cur_mode) ? cur_root : '0;
   assign busy_o = busy;
endmodule

// File: rtl/dirptr_ctrl_chk.sv
module dirptr_ctrl_chk #(
   parameter int unsigned MAX_LEVELS    = 2,
   parameter bit          FIXED_ROOT_EN = 1'b1,
   parameter logic [43:0] FIXED_ROOT    = '0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [63:0] wr_data,
   input logic [63:0] rd_data,
   input logic [3:0]  mode_o,
   input logic [43:0] root_o,
   input logic        busy_o
);
   p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && wr_en |=> $stable(mode_o) && $stable(rd_data[53:10]));

   p_no_level_hop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o >= 4'd2) |=> (mode_o == $past(mode_o)) || (mode_o <= 4'd1));

   p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o <= 4'(MAX_LEVELS + 1));

   p_busy_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_o) |-> busy_o);

   p_fixed_root_r9: assert property (@(posedge clk) disable iff (!rst_n)
      FIXED_ROOT_EN && !$stable(rd_data[53:10]) && (rd_data[3:0] <= 4'd1)
      |-> rd_data[53:10] == FIXED_ROOT);

   p_walker_view_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == rd_data[3:0]) && (busy_o == rd_data[4]));
endmodule

bind dirptr_ctrl dirptr_ctrl_chk #(
   .MAX_LEVELS(MAX_LEVELS), .FIXED_ROOT_EN(FIXED_ROOT_EN), .FIXED_ROOT(FIXED_ROOT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .mode_o(mode_o), .root_o(root_o), .busy_o(busy_o)
);

// File: tb/dirptr_ctrl_bench.sv
`timescale 1ns/1ps
module dirptr_ctrl_bench;
   localparam int unsigned MAXL  = 2;
   localparam int unsigned BUSYC = 4;
   localparam logic [43:0] FIXR  = 44'h000_00AB_CDE1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic [63:0] rd_data;
   logic [3:0]  mode_o;
   logic [43:0] root_o;
   logic        busy_o;

   int checks = 0, fails = 0;
   logic [3:0]  m_mode = 4'd0;
   logic [43:0] m_root = '0;
   int          m_cnt = 0;

   always #2.5 clk = ~clk;

   dirptr_ctrl #(.MAX_LEVELS(MAXL), .BUSY_CYCLES(BUSYC), .FIXED_ROOT_EN(1'b1),
                 .FIXED_ROOT(FIXR)) u_dirptr_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .mode_o(mode_o), .root_o(root_o), .busy_o(busy_o));

   function automatic logic [3:0] legal(input logic [3:0] m);
      if (m > 4'd4) return 4'd0;
      if (m <= 4'd1 || m <= 4'(MAXL + 1)) return m;
      return 4'(MAXL + 1);
   endfunction

   function automatic logic [63:0] word(input logic [3:0] m, input logic [43:0] r);
      // junk in bits 63:54, 9:4 must be ignored (R2)
      return {10'h3FF, r, 6'h3F, m};
   endfunction

   function automatic logic [63:0] exp_rd();
      return {10'h0, m_root, 5'h0, (m_cnt != 0), m_mode};
   endfunction

   task automatic model_edge(input logic we, input logic [63:0] d);
      logic [3:0] nm;
      logic acc;
      nm  = legal(d[3:0]);
      acc = we && (m_cnt == 0) && !(m_mode >= 4'd2 && nm >= 4'd2 && nm != m_mode);
      if (m_cnt != 0) m_cnt--;
      if (acc) begin
         if (nm != m_mode) m_cnt = BUSYC;
         m_root = (nm <= 4'd1) ? FIXR : d[53:10];
         m_mode = nm;
      end
   endtask

   task automatic check(input string tag);
      logic [43:0] er;
      er = (m_mode >= 4'd2) ? m_root : 44'h0;
      checks++;
      if (rd_data !== exp_rd() || mode_o !== m_mode || root_o !== er
          || busy_o !== (m_cnt != 0)) begin
         fails++;
         $display("FAIL %s: rd=%h mode=%0d root=%h busy=%b exp rd=%h mode=%0d root=%h busy=%b",
                  tag, rd_data, mode_o, root_o, busy_o, exp_rd(), m_mode, er, (m_cnt != 0));
      end
   endtask

   task automatic step(input logic we, input logic [63:0] d, input string tag);
      @(negedge clk);
      wr_en = we;
      wr_data = d;
      @(posedge clk);
      model_edge(we, d);
      #1;
      check(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, '0, tag);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd7341));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #0 check("R1 reset");
      idle(1, "R1 reset hold");

      step(1'b1, word(4'd3, 44'h123_4567_89AB), "R4 accept L2");
      idle(BUSYC - 1, "R7 busy held");
      step(1'b1, word(4'd1, 44'h1), "R8 write on last busy cycle dropped");
      step(1'b1, word(4'd2, 44'h222), "R6 L2 to L1 ignored");
      step(1'b1, word(4'd4, 44'h0AA_BBCC_DDEE), "R11 R5 L3 legalises to L2, root only");
      step(1'b1, word(4'd1, 44'h555), "R3 R9 BARE stores fixed root");
      step(1'b1, word(4'd0, 44'h777), "R8 write while busy dropped");
      idle(BUSYC, "R7 busy clears");
      step(1'b1, word(4'd9, 44'h999), "R5 code 9 reads OFF");
      idle(BUSYC, "R7");
      step(1'b1, word(4'd4, 44'h0FF_0000_1234), "R5 L3 from OFF gives L2");
      idle(BUSYC, "R10 walker root");
      step(1'b1, word(4'd0, 44'h3), "R3 OFF from table mode");
      idle(BUSYC, "R7");
      step(1'b1, word(4'd2, 44'h0123), "R4 accept L1");
      idle(BUSYC, "R10");

      for (int i = 0; i < 4000; i++) begin
         logic [3:0]  m;
         logic [43:0] r;
         m = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'($urandom % 5);
         r = {12'($urandom), 32'($urandom)};
         step(($urandom % 3) == 0, {$urandom, $urandom} ^ word(m, r) & 64'h003F_FFFF_FFFF_FC0F | word(m, r) & 64'h003F_FFFF_FFFF_FC0F, "R2 random");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule